// File: doc/BRIEF.md
# Time-Slot Routed Register Storage

This block keeps intermediate samples alive between operations of a cyclic, statically scheduled datapath. Samples enter at one end of a chain of word registers and move one position per clock. A slot counter runs from 0 to the schedule period minus one and then wraps. Each slot, a constant routing table picks one of two things. It chooses which feedback path, if any, overwrites one register of the chain with the contents of another, so that a sample can be held longer than a plain delay line would hold it. It also chooses which tap register is copied to the single output.

The routing is fixed at elaboration through packed parameter vectors. These are the per-slot feedback select, the per-slot output-tap select, the source and destination register of every feedback path, and the register index behind every output tap. The two selects come from registers, so a table entry takes effect one clock after the counter shows its slot. There is one state variable, the slot counter, with states SLOT_0 … SLOT_(PERIOD-1). Its only transitions are ADVANCE (slot t to slot t+1), WRAP (last slot to SLOT_0) and RESTART (any slot to SLOT_0 under reset).

Top module: `sched_reg_store`

## Requirements
- R1: The slot counter steps by one every clock while reset is low, stays below PERIOD, and returns to 0 after PERIOD-1, so the routing repeats every PERIOD cycles.
- R2: On every clock the chain register 0 loads `din` and register i loads register i-1, except where R3 overrides one register.
- R3: When the applied feedback select holds k with k ≥ 1, register BE_DST[k] loads the pre-edge contents of register BE_SRC[k] and every other register shifts as in R2. A select of 0 means plain shifting. Edge k's register index sits in bits [(k-1)*IW +: IW] of BE_SRC and BE_DST.
- R4: When the applied output select holds j, the next clock loads `dout` with the pre-edge contents of register OUT_REG[j]. Tap j's index sits in bits [j*IW +: IW] of OUT_REG.
- R5: The table entry for slot t (feedback field at BE_TAB bits [t*BW +: BW], tap field at OUT_TAB bits [t*OW +: OW]) is latched into the selects at the clock that ends the cycle where the counter shows t. It therefore steers the chain and the output at the clock after that.
- R6: A synchronous reset sets the counter to 0, both selects to 0 and `dout` to 0. It does not clear the data registers, which go on shifting.
- R7: After reset is released, the schedule starts again at slot 0. This holds for a reset in mid-run too, and the contents of the chain are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | WL | Sample entering chain register 0 |
| dout | output | WL | Registered output tap |

## Verification
The bench builds the block with five registers, a six-slot period, two feedback paths and three output taps, rather than the defaults. With these values the select fields are two bits wide and the register indices three bits wide, on a register count that is not a power of two. One feedback path reaches the chain head and another crosses to the middle. Both feedback selects and every tap appear in the table within one period. A mid-run reset falls on a slot other than 0, so the restart is seen with a populated chain whose contents come through the reset.

// File: rtl/sched_reg_store_pkg.sv
package sched_reg_store_pkg;

    // Width of a field able to index n distinct values (at least one bit).
    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sst_slot_counter.sv
module sst_slot_counter
    import sched_reg_store_pkg::*;
#(
    parameter int PERIOD = 4,
    parameter int CW     = idx_w(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] slot
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef enum logic [1:0] {
        ADVANCE = 2'd0,
        WRAP    = 2'd1,
        RESTART = 2'd2
    } slot_move_t;

    slot_move_t move;

    always_comb begin
        if (rst)
            move = RESTART;
        else if (slot == LAST)
            move = WRAP;
        else
            move = ADVANCE;
    end

    always_ff @(posedge clk) begin
        unique case (move)
            RESTART: slot <= '0;
            WRAP:    slot <= '0;
            ADVANCE: slot <= slot + CW'(1);
            default: slot <= '0;
        endcase
    end
endmodule

// File: rtl/sst_route_decode.sv
module sst_route_decode
    import sched_reg_store_pkg::*;
#(
    parameter int                   PERIOD  = 4,
    parameter int                   CW      = 2,
    parameter int                   BW      = 1,
    parameter int                   OW      = 1,
    parameter logic [PERIOD*BW-1:0] BE_TAB  = '0,
    parameter logic [PERIOD*OW-1:0] OUT_TAB = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] slot,
    output logic [BW-1:0] be_sel,
    output logic [OW-1:0] out_sel
);
    logic [BW-1:0] be_entry;
    logic [OW-1:0] out_entry;

    always_comb begin
        be_entry  = '0;
        out_entry = '0;
        for (int t = 0; t < PERIOD; t++) begin
            if (slot == CW'(t)) begin
                be_entry  = BE_TAB[t*BW +: BW];
                out_entry = OUT_TAB[t*OW +: OW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            be_sel  <= '0;
            out_sel <= '0;
        end else begin
            be_sel  <= be_entry;
            out_sel <= out_entry;
        end
    end
endmodule

// File: rtl/sst_reg_chain.sv
module sst_reg_chain
    import sched_reg_store_pkg::*;
#(
    parameter int                    WL      = 8,
    parameter int                    REG_CNT = 4,
    parameter int                    N_BACK  = 1,
    parameter int                    BW      = 1,
    parameter int                    IW      = 2,
    parameter logic [N_BACK*IW-1:0]  BE_SRC  = '0,
    parameter logic [N_BACK*IW-1:0]  BE_DST  = '0
) (
    input  logic                  clk,
    input  logic [WL-1:0]         din,
    input  logic [BW-1:0]         be_sel,
    output logic [REG_CNT*WL-1:0] chain
);
    logic [WL-1:0] regs [REG_CNT];
    logic [WL-1:0] nxt  [REG_CNT];

    for (genvar i = 0; i < REG_CNT; i++) begin : g_cell
        always_comb begin
            if (i == 0)
                nxt[i] = din;
            else
                nxt[i] = regs[(i == 0) ? 0 : i - 1];
            for (int k = 1; k <= N_BACK; k++) begin
                if (be_sel == BW'(k) && BE_DST[(k-1)*IW +: IW] == IW'(i))
                    nxt[i] = regs[BE_SRC[(k-1)*IW +: IW]];
            end
        end

        always_ff @(posedge clk) begin
            regs[i] <= nxt[i];
        end

        assign chain[i*WL +: WL] = regs[i];
    end
endmodule

// File: rtl/sst_out_mux.sv
module sst_out_mux
    import sched_reg_store_pkg::*;
#(
    parameter int                   WL      = 8,
    parameter int                   REG_CNT = 4,
    parameter int                   N_OUT   = 2,
    parameter int                   OW      = 1,
    parameter int                   IW      = 2,
    parameter logic [N_OUT*IW-1:0]  OUT_REG = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_CNT*WL-1:0] chain,
    input  logic [OW-1:0]         out_sel,
    output logic [WL-1:0]         dout
);
    logic [WL-1:0] picked;

    always_comb begin
        picked = '0;
        for (int j = 0; j < N_OUT; j++) begin
            if (out_sel == OW'(j)) begin
                for (int r = 0; r < REG_CNT; r++) begin
                    if (OUT_REG[j*IW +: IW] == IW'(r))
                        picked = chain[r*WL +: WL];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else
            dout <= picked;
    end
endmodule

// File: rtl/sched_reg_store.sv
module sched_reg_store
    import sched_reg_store_pkg::*;
#(
    parameter int WL      = 8,
    parameter int REG_CNT = 4,
    parameter int PERIOD  = 4,
    parameter int N_BACK  = 1,
    parameter int N_OUT   = 2,
    parameter logic [N_BACK*idx_w(REG_CNT)-1:0]   BE_SRC  = 2'd3,
    parameter logic [N_BACK*idx_w(REG_CNT)-1:0]   BE_DST  = 2'd0,
    parameter logic [N_OUT*idx_w(REG_CNT)-1:0]    OUT_REG = {2'd3, 2'd1},
    parameter logic [PERIOD*idx_w(N_BACK+1)-1:0]  BE_TAB  = 4'b1000,
    parameter logic [PERIOD*idx_w(N_OUT)-1:0]     OUT_TAB = 4'b1010
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [WL-1:0] din,
    output logic [WL-1:0] dout
);
    localparam int CW = idx_w(PERIOD);
    localparam int BW = idx_w(N_BACK + 1);
    localparam int OW = idx_w(N_OUT);
    localparam int IW = idx_w(REG_CNT);

    logic [CW-1:0]         slot;
    logic [BW-1:0]         be_sel;
    logic [OW-1:0]         out_sel;
    logic [REG_CNT*WL-1:0] chain;

    sst_slot_counter #(.PERIOD(PERIOD), .CW(CW)) u_slot (
        .clk (clk),
        .rst (rst),
        .slot(slot)
    );

    sst_route_decode #(
        .PERIOD(PERIOD), .CW(CW), .BW(BW), .OW(OW),
        .BE_TAB(BE_TAB), .OUT_TAB(OUT_TAB)
    ) u_route (
        .clk    (clk),
        .rst    (rst),
        .slot   (slot),
        .be_sel (be_sel),
        .out_sel(out_sel)
    );

    sst_reg_chain #(
        .WL(WL), .REG_CNT(REG_CNT), .N_BACK(N_BACK), .BW(BW), .IW(IW),
        .BE_SRC(BE_SRC), .BE_DST(BE_DST)
    ) u_chain (
        .clk   (clk),
        .din   (din),
        .be_sel(be_sel),
        .chain (chain)
    );

    sst_out_mux #(
        .WL(WL), .REG_CNT(REG_CNT), .N_OUT(N_OUT), .OW(OW), .IW(IW),
        .OUT_REG(OUT_REG)
    ) u_omux (
        .clk    (clk),
        .rst    (rst),
        .chain  (chain),
        .out_sel(out_sel),
        .dout   (dout)
    );
endmodule

// File: rtl/sched_reg_store_chk.sv
module sched_reg_store_chk #(
    parameter int                   PERIOD  = 4,
    parameter int                   WL      = 8,
    parameter int                   CW      = 2,
    parameter int                   BW      = 1,
    parameter int                   OW      = 1,
    parameter logic [PERIOD*BW-1:0] BE_TAB  = '0,
    parameter logic [PERIOD*OW-1:0] OUT_TAB = '0
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] slot,
    input logic [BW-1:0] be_sel,
    input logic [OW-1:0] out_sel,
    input logic [WL-1:0] dout
);
    function automatic logic [BW-1:0] be_at(input logic [CW-1:0] t);
        return BE_TAB[t*BW +: BW];
    endfunction

    function automatic logic [OW-1:0] out_at(input logic [CW-1:0] t);
        return OUT_TAB[t*OW +: OW];
    endfunction

    a_r1_range: assert property (@(posedge clk) disable iff (rst)
        32'(slot) < PERIOD);

    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (32'(slot) == PERIOD - 1) |=> (slot == '0));

    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (32'(slot) != PERIOD - 1) |=> (slot == $past(slot) + CW'(1)));

    a_r5_be_latch: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (be_sel == be_at($past(slot))));

    a_r5_out_latch: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (out_sel == out_at($past(slot))));

    a_r6_reset: assert property (@(posedge clk)
        rst |=> (slot == '0 && be_sel == '0 && out_sel == '0 && dout == '0));
endmodule

bind sched_reg_store sched_reg_store_chk #(
    .PERIOD(PERIOD), .WL(WL), .CW(CW), .BW(BW), .OW(OW),
    .BE_TAB(BE_TAB), .OUT_TAB(OUT_TAB)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .slot   (slot),
    .be_sel (be_sel),
    .out_sel(out_sel),
    .dout   (dout)
);

// File: tb/sched_reg_store_tb.sv
`timescale 1ns/1ps
module sched_reg_store_tb;
    localparam int P   = 6;
    localparam int NR  = 5;
    localparam int WL  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [WL-1:0] din = '0;
    logic [WL-1:0] dout;

    always #2 clk = ~clk;

    sched_reg_store #(
        .WL(WL), .REG_CNT(NR), .PERIOD(P), .N_BACK(2), .N_OUT(3),
        .BE_SRC ({3'd2, 3'd4}),
        .BE_DST ({3'd3, 3'd0}),
        .OUT_REG({3'd4, 3'd2, 3'd0}),
        .BE_TAB ({2'd0, 2'd0, 2'd2, 2'd0, 2'd1, 2'd0}),
        .OUT_TAB({2'd2, 2'd0, 2'd1, 2'd2, 2'd1, 2'd0})
    ) u_dut (
        .clk (clk),
        .rst (rst),
        .din (din),
        .dout(dout)
    );

    // Reference tables, written from the requirements.
    int t_be  [P]  = '{0, 1, 0, 2, 0, 0};
    int t_out [P]  = '{0, 1, 2, 1, 0, 2};
    int e_src [3]  = '{0, 4, 2};
    int e_dst [3]  = '{0, 0, 3};
    int tap   [3]  = '{0, 2, 4};

    int m_reg [NR];
    bit m_val [NR];
    int m_cnt = 0, m_be = 0, m_os = 0, m_dout = 0;
    bit m_dv = 1'b0;
    int since_rst = 0;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic model_edge();
        int nr [NR];
        bit nv [NR];
        for (int i = 0; i < NR; i++) begin
            nr[i] = (i == 0) ? int'(din) : m_reg[i-1];
            nv[i] = (i == 0) ? 1'b1 : m_val[i-1];
        end
        if (m_be != 0) begin
            nr[e_dst[m_be]] = m_reg[e_src[m_be]];
            nv[e_dst[m_be]] = m_val[e_src[m_be]];
        end
        if (rst) begin
            m_dout = 0; m_dv = 1'b1;
            m_cnt = 0; m_be = 0; m_os = 0;
            since_rst = 0;
        end else begin
            m_dout = m_reg[tap[m_os]];
            m_dv   = m_val[tap[m_os]];
            m_be   = t_be[m_cnt];
            m_os   = t_out[m_cnt];
            m_cnt  = (m_cnt + 1) % P;
            since_rst++;
        end
        for (int i = 0; i < NR; i++) begin
            m_reg[i] = nr[i];
            m_val[i] = nv[i];
        end
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if (dout !== WL'(m_dout)) begin
            n_bad++;
            $display("FAIL %s: dout actual %0d expected %0d at %0t",
                     tag, dout, m_dout, $time);
        end
    endtask

    task automatic step(input bit r, input logic [WL-1:0] d);
        string tag;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rst)
            tag = "R6 reset state";
        else if (since_rst <= P + 2)
            tag = "R7 restart R1 R5";
        else if (m_be != 0)
            tag = "R3 feedback R1 R5";
        else
            tag = "R2 R4 shift/tap R1 R5";
        if (m_dv) compare(tag);
        rst = r;
        din = d;
    endtask

    initial begin
        logic [WL-1:0] lfsr = 8'hA5;
        for (int i = 0; i < NR; i++) begin
            m_reg[i] = 0;
            m_val[i] = 1'b0;
        end
        // reset, incrementing stream
        for (int c = 0; c < 3; c++) step(1'b1, WL'(c + 1));
        for (int c = 0; c < 30; c++) step(1'b0, WL'(c * 3 + 7));
        // pseudo-random stream
        for (int c = 0; c < 23; c++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(1'b0, lfsr);
        end
        // mid-run reset on a non-zero slot, chain kept (R6, R7)
        for (int c = 0; c < 2; c++) step(1'b1, WL'(8'hC0 + c));
        // alternating pattern over several periods
        for (int c = 0; c < 40; c++)
            step(1'b0, (c % 2 == 0) ? 8'h55 : 8'hAA ^ WL'(c));
        for (int c = 0; c < 6; c++) step(1'b0, 8'hFF);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule